// File: doc/BRIEF.md
# Two-stage windowed watchdog timer

This block is a clocked supervisor for a host that must prove, at regular intervals, that it is still running. Once started, a first-stage counter runs up towards a programmable timeout. The host restarts it with a kick strobe, but the kick only counts inside an acceptance window. A kick that comes too soon is rejected and latched as a fault. A configuration bit can instead make such a kick end the first stage at once.

When the first stage runs out, the block does three things in the same cycle. It raises a non-maskable interrupt request, switches every control output to a fixed safe pattern, and starts a second-stage counter. The second stage gives the host time to record its state. If the second stage also runs out, the block drives a system reset pulse of fixed length and then returns to idle. The host can stop the timer at any point, which also returns it to idle.

Top module: `twostage_watchdog`

## Requirements
- R1: While running, a first-stage count starts at 0 on the cycle after `start` and advances once per cycle. With no accepted kick, `nmi_req` becomes visible exactly `cfg_timeout` cycles after the start edge, and a timeout of 0 behaves as 1. An accepted kick restarts the count at 0 and takes priority over expiry in the same cycle.
- R2: `nmi_req` rises on the same edge at which the first stage expires and the second stage begins. It stays high through the second stage and through the reset pulse.
- R3: From first-stage expiry until the reset pulse ends, `ctrl_out` equals the parameter `SAFE_VALUE`. At all other times `ctrl_out` equals `ctrl_in`.
- R4: `sys_rst` rises `cfg_delay` cycles after `nmi_req` rises and stays high for exactly `RST_LEN` cycles.
- R5: A kick is accepted only when the current first-stage count is at least `cfg_open`. An earlier kick leaves the count advancing unchanged and sets the sticky output `kick_fault`.
- R6: `kick_fault` is cleared by a one-cycle `fault_clr`. If an early kick arrives in the same cycle as `fault_clr`, the fault is set, because setting wins.
- R7: With `early_trip` high, an early kick ends the first stage on that edge, so `nmi_req` is visible in the next cycle.
- R8: After the first stage has expired, kicks are ignored. They do not delay `sys_rst` and do not clear `nmi_req`.
- R9: When the reset pulse ends, the block is idle: `nmi_req` and `sys_rst` are low, `ctrl_out` follows `ctrl_in`, and nothing restarts until a new `start`.
- R10: `stop` returns the block to idle from any state on the next edge and takes priority over `start`. While idle, `nmi_req` and `sys_rst` are never raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start the first stage from idle |
| stop | input | 1 | Return to idle from any state |
| kick | input | 1 | Restart strobe from the host |
| early_trip | input | 1 | Treat an early kick as immediate expiry |
| fault_clr | input | 1 | Write-one-to-clear for `kick_fault` |
| cfg_timeout | input | CW | First-stage timeout in cycles |
| cfg_delay | input | CW | Second-stage delay in cycles |
| cfg_open | input | CW | Count at which the kick window opens |
| ctrl_in | input | NOUT | Control values from the host |
| ctrl_out | output | NOUT | Control outputs, forced safe after expiry |
| nmi_req | output | 1 | Non-maskable interrupt request |
| sys_rst | output | 1 | System reset pulse |
| kick_fault | output | 1 | Sticky early-kick fault |

## Verification
The bench probes kicks at the exact opening count, one count before it, and on the final cycle before expiry. A design with an off-by-one window compare would wrongly accept or reject one of these. A design that lets expiry beat a same-cycle kick would raise the interrupt early. The bench also kicks during the second stage, where a design that still honoured kicks would delay or suppress the reset. It checks that forcing is released once the pulse ends, that a cleared fault cannot mask an early kick arriving in the same cycle, and that stop beats start, since a wrong priority here would let the timer run.

// File: rtl/twostage_watchdog.sv
module twostage_watchdog #(
  parameter int CW = 8,
  parameter int NOUT = 8,
  parameter logic [NOUT-1:0] SAFE_VALUE = 8'h3C,
  parameter int RST_LEN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic            kick,
  input  logic            early_trip,
  input  logic            fault_clr,
  input  logic [CW-1:0]   cfg_timeout,
  input  logic [CW-1:0]   cfg_delay,
  input  logic [CW-1:0]   cfg_open,
  input  logic [NOUT-1:0] ctrl_in,
  output logic [NOUT-1:0] ctrl_out,
  output logic            nmi_req,
  output logic            sys_rst,
  output logic            kick_fault
);
  localparam logic [CW:0] RLEN = RST_LEN[CW:0];

  typedef enum logic [1:0] {IDLE, RUN, STG2, RSTP} state_t;
  state_t state;
  logic [CW-1:0] cnt;

  wire [CW:0] cnt_nx = {1'b0, cnt} + 1'b1;
  wire in_run   = (state == RUN);
  wire kick_ok  = in_run && kick && (cnt >= cfg_open);
  wire early    = in_run && kick && (cnt < cfg_open) && !stop;
  wire forced   = (state == STG2) || (state == RSTP);

  assign nmi_req    = forced;
  assign sys_rst    = (state == RSTP);
  assign ctrl_out   = forced ? SAFE_VALUE : ctrl_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= IDLE;
      cnt        <= '0;
      kick_fault <= 1'b0;
    end else begin
      if (fault_clr) kick_fault <= 1'b0;
      if (early) kick_fault <= 1'b1;
      if (stop) begin
        state <= IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          IDLE: if (start) begin
            state <= RUN;
            cnt   <= '0;
          end
          RUN: begin
            if (kick_ok) cnt <= '0;
            else if ((early && early_trip) || (cnt_nx >= {1'b0, cfg_timeout})) begin
              state <= STG2;
              cnt   <= '0;
            end else cnt <= cnt_nx[CW-1:0];
          end
          STG2: begin
            if (cnt_nx >= {1'b0, cfg_delay}) begin
              state <= RSTP;
              cnt   <= '0;
            end else cnt <= cnt_nx[CW-1:0];
          end
          default: begin
            if (cnt_nx >= RLEN) begin
              state <= IDLE;
              cnt   <= '0;
            end else cnt <= cnt_nx[CW-1:0];
          end
        endcase
      end
    end
  end

  a_r1_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && kick && (cnt >= cfg_open) && !stop) |=> (in_run && cnt == '0));

  a_r2_nmi_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_req) |-> $past(state == RUN));

  a_r4_rst_after_nmi: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> $past(nmi_req));

  a_r5_early_sets_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && kick && (cnt < cfg_open) && !stop) |=> kick_fault);

  a_r8_no_return_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (forced && !stop) |=> (state != RUN));

  a_r9_idle_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (!nmi_req && ctrl_out == ctrl_in));

  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (state == IDLE && !nmi_req && !sys_rst));
endmodule

// File: tb/twostage_watchdog_tb.sv
module twostage_watchdog_tb;
  localparam int CW = 8;
  localparam int NOUT = 8;
  localparam logic [7:0] SAFE = 8'h3C;
  localparam int RLEN = 4;
  localparam logic [7:0] CIN = 8'hA5;

  logic clk = 0, rst_n = 0, start = 0, stop = 0, kick = 0, early_trip = 0, fault_clr = 0;
  logic [CW-1:0] cfg_timeout = 8'd10, cfg_delay = 8'd5, cfg_open = 8'd3;
  logic [NOUT-1:0] ctrl_in = CIN;
  logic [NOUT-1:0] ctrl_out;
  logic nmi_req, sys_rst, kick_fault;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  twostage_watchdog #(.CW(CW), .NOUT(NOUT), .SAFE_VALUE(SAFE), .RST_LEN(RLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .kick(kick),
    .early_trip(early_trip), .fault_clr(fault_clr), .cfg_timeout(cfg_timeout),
    .cfg_delay(cfg_delay), .cfg_open(cfg_open), .ctrl_in(ctrl_in),
    .ctrl_out(ctrl_out), .nmi_req(nmi_req), .sys_rst(sys_rst), .kick_fault(kick_fault));

  // fields: timeout, open, kick count, trip, expected fault, expected cycles to nmi
  localparam logic [33:0] VEC [0:5] = '{
    {8'd10, 8'd3, 8'd5, 1'b0, 1'b0, 8'd10},
    {8'd10, 8'd3, 8'd3, 1'b0, 1'b0, 8'd10},
    {8'd10, 8'd3, 8'd2, 1'b0, 1'b1, 8'd7},
    {8'd10, 8'd3, 8'd2, 1'b1, 1'b1, 8'd0},
    {8'd10, 8'd3, 8'd9, 1'b0, 1'b0, 8'd10},
    {8'd6,  8'd0, 8'd0, 1'b0, 1'b0, 8'd6}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic pulse_stop();
    stop = 1; @(negedge clk); stop = 0;
  endtask

  task automatic pulse_clr();
    fault_clr = 1; @(negedge clk); fault_clr = 0;
  endtask

  task automatic count_to_nmi(output int n);
    n = 0;
    while (!nmi_req && n < 60) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R9 reset nmi", nmi_req, 0);
    chk("R9 reset sys_rst", sys_rst, 0);
    chk("R6 reset fault", kick_fault, 0);
    chk("R3 reset ctrl", ctrl_out, CIN);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      cfg_timeout = VEC[i][33:26];
      cfg_open    = VEC[i][25:18];
      early_trip  = VEC[i][9];
      pulse_start();
      repeat (VEC[i][17:10]) @(negedge clk);
      kick = 1; @(negedge clk); kick = 0;
      chk($sformatf("R5 vec%0d fault", i), kick_fault, VEC[i][8]);
      count_to_nmi(n);
      chk($sformatf("R1 R7 vec%0d cycles to nmi", i), n, VEC[i][7:0]);
      pulse_stop();
      pulse_clr();
    end
    early_trip = 0;

    repeat (30) @(negedge clk);
    chk("R10 no nmi while idle", nmi_req, 0);

    cfg_timeout = 8'd8; cfg_open = 8'd2; cfg_delay = 8'd5;
    pulse_start();
    count_to_nmi(n);
    chk("R1 free-running timeout", n, 8);
    chk("R3 ctrl forced safe", ctrl_out, SAFE);
    chk("R2 nmi high", nmi_req, 1);
    kick = 1; @(negedge clk); kick = 0;
    n = 1;
    while (!sys_rst && n < 60) begin @(negedge clk); n++; end
    chk("R4 R8 delay to reset with kick in stage 2", n, 5);
    chk("R2 nmi held in reset pulse", nmi_req, 1);
    n = 0;
    while (sys_rst && n < 60) begin @(negedge clk); n++; end
    chk("R4 reset pulse length", n, RLEN);
    chk("R9 nmi cleared", nmi_req, 0);
    chk("R9 ctrl released", ctrl_out, CIN);
    repeat (20) @(negedge clk);
    chk("R9 no restart", nmi_req, 0);

    pulse_start();
    repeat (3) @(negedge clk);
    pulse_stop();
    repeat (20) @(negedge clk);
    chk("R10 stop during run", nmi_req, 0);
    start = 1; stop = 1; @(negedge clk); start = 0; stop = 0;
    repeat (20) @(negedge clk);
    chk("R10 stop beats start", nmi_req, 0);

    pulse_start();
    count_to_nmi(n);
    pulse_stop();
    chk("R10 stop in stage 2 nmi", nmi_req, 0);
    chk("R10 stop in stage 2 ctrl", ctrl_out, CIN);

    pulse_start();
    kick = 1; @(negedge clk);
    chk("R5 early kick fault", kick_fault, 1);
    fault_clr = 1; @(negedge clk); kick = 0; fault_clr = 0;
    chk("R6 set wins over clear", kick_fault, 1);
    pulse_clr();
    chk("R6 clear", kick_fault, 0);
    pulse_stop();

    cfg_timeout = 8'd0;
    pulse_start();
    count_to_nmi(n);
    chk("R1 zero timeout acts as one", n, 1);
    pulse_stop();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule